// File: doc/BRIEF.md
# Variable-Page-Size Associative Translation Buffer

This block is a 64-slot, fully associative address translation buffer. Each slot stores a 64-bit tag word and a 64-bit translation word. The tag word holds the virtual page and the context. Bit 63 of the translation word marks the slot valid. Bits 62:61 of the translation word give the page size. Each slot's page size sets how many page-offset bits of the tag are left out of its compare, so slots with different page sizes can sit together in one array.

The block has three ports:

- A write port loads both words of one slot in a single clock.
- A direct read port returns the translation word of the slot selected by address bits 8:3.
- A lookup port compares a presented tag against every valid slot at once. It returns the translation word of the winning slot, together with hit, miss and index flags.

The instruction-side and data-side buffers are two instances of the same module. Refill and replacement decisions are made outside the block.

Top module: `vpa_tlb`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, slot `wr_idx` takes `wr_tag` and `wr_entry` together. A lookup or direct read in the same cycle as the write still sees the old slot contents.
- R2: A low `rst_n` at a rising edge clears bit 63 (valid) of every slot's translation word and leaves all other stored bits unchanged. No lookup hits until a new valid slot is written.
- R3: A slot takes part in lookup only when bit 63 of its translation word is 1.
- R4: Bits 62:61 of a slot's translation word select its compare mask:
  - Code 0 compares all 64 tag bits.
  - Code 1 ignores tag bits 15:12.
  - Code 2 ignores tag bits 18:12.
  - Code 3 ignores tag bits 21:12.
  - Bits 11:0 and all bits above the ignored range are always compared.
- R5: A slot hits when its stored tag and `lk_tag` agree on every bit its mask keeps. On a hit, `lk_hit` is 1 and `lk_miss` is 0. `lk_entry` carries the hitting slot's translation word (not its tag word), and `lk_idx` carries its slot number.
- R6: When several valid slots hit, the lowest-numbered slot wins.
- R7: `rd_entry` returns the translation word of the slot numbered by `rd_addr[8:3]`, whether or not that slot is valid.
- R8: When no valid slot hits, `lk_entry` is all zeros, `lk_idx` is 0, `lk_miss` is 1 and `lk_hit` is 0.
- R9: Lookup and direct read outputs follow their inputs combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all valid bits |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Slot number to write |
| wr_tag | input | 64 | Tag word to store |
| wr_entry | input | 64 | Translation word to store (bit 63 valid, bits 62:61 page size) |
| rd_addr | input | 64 | Direct read address; bits 8:3 select the slot |
| rd_entry | output | 64 | Translation word of the addressed slot |
| lk_tag | input | 64 | Tag presented for associative lookup |
| lk_entry | output | 64 | Translation word of the winning slot, zero on miss |
| lk_hit | output | 1 | A valid slot matched |
| lk_miss | output | 1 | No valid slot matched |
| lk_idx | output | 6 | Number of the winning slot, zero on miss |

## Verification
The assertions assume the following about the inputs:

- `rst_n`, `wr_en`, `wr_idx`, `rd_addr` and `lk_tag` are known (never X) at each rising edge.
- `rst_n` is released between edges.

Under these conditions, a write is visible at its own slot on the next edge, and an asserted reset leaves no hit one edge later. The stimulus meets these conditions as follows:

- Every input changes only on the falling clock edge.
- Each write index is drawn from the 64 legal slots.
- Reset is raised and dropped on falling edges, both at the start and once in mid-run.

// File: rtl/vtlb_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, bit positions of the translation word, and the
// page-size compare mask. Assumes 64-bit words with page offsets from bit 12.
package vtlb_pkg;
    localparam int WORD_W   = 64;
    localparam int VALID_B  = 63;
    localparam int SIZE_HI  = 62;
    localparam int SIZE_LO  = 61;
    localparam int PAGE_LSB = 12;

    // Number of tag bits above PAGE_LSB that a size code leaves out of the compare.
    function automatic int size_span(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 4;
            2'd2:    return 7;
            default: return 10;
        endcase
    endfunction

    // Compare mask for one slot: ones where the tag is compared.
    function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] code);
        logic [WORD_W-1:0] m;
        int span;
        span = size_span(code);
        m = '1;
        for (int b = 0; b < WORD_W; b++) begin
            if (b >= PAGE_LSB && b < PAGE_LSB + span) m[b] = 1'b0;
        end
        return m;
    endfunction
endpackage

// File: rtl/vtlb_store.sv
`timescale 1ns/1ps
// Slot storage: a tag word and a translation word per slot.
// The valid bit is held in its own reset flop. The rest of each word has no
// reset. A write updates both words of one slot at the clock edge.
module vtlb_store
    import vtlb_pkg::*;
#(
    parameter int SLOTS = 64,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WORD_W-1:0]             wr_tag,
    input  logic [WORD_W-1:0]             wr_entry,
    output logic [SLOTS-1:0][WORD_W-1:0]  tag_q,
    output logic [SLOTS-1:0][WORD_W-1:0]  ent_q
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic              valid_q;
        logic [VALID_B-1:0] body_q;
        logic [WORD_W-1:0] tagw_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(s));

        // Valid bit: cleared by reset, loaded on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)   valid_q <= 1'b0;
            else if (sel) valid_q <= wr_entry[VALID_B];
        end

        // Tag and entry body: loaded on a write, kept through reset.
        always_ff @(posedge clk) begin
            if (rst_n && sel) begin
                tagw_q <= wr_tag;
                body_q <= wr_entry[VALID_B-1:0];
            end
        end

        assign tag_q[s] = tagw_q;
        assign ent_q[s] = {valid_q, body_q};
    end
endmodule

// File: rtl/vtlb_match.sv
`timescale 1ns/1ps
// Per-slot compare: each valid slot masks its stored tag and the lookup tag
// with the mask selected by its own page-size field. Purely combinational.
module vtlb_match
    import vtlb_pkg::*;
#(
    parameter int SLOTS = 64
) (
    input  logic [SLOTS-1:0][WORD_W-1:0] tag_q,
    input  logic [SLOTS-1:0][WORD_W-1:0] ent_q,
    input  logic [WORD_W-1:0]            lk_tag,
    output logic [SLOTS-1:0]             hit_vec
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        logic [WORD_W-1:0] mask;

        // Slot hit: valid, and no differing bit survives the slot mask.
        always_comb begin
            mask       = size_mask(ent_q[s][SIZE_HI:SIZE_LO]);
            hit_vec[s] = ent_q[s][VALID_B] && (((tag_q[s] ^ lk_tag) & mask) == '0);
        end
    end
endmodule

// File: rtl/vtlb_prio.sv
`timescale 1ns/1ps
// Priority encoder: the lowest set bit of the hit vector wins.
// The index is zero when nothing is set.
module vtlb_prio #(
    parameter int SLOTS = 64,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] hit_vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest hitting slot is written last.
    always_comb begin
        idx = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (hit_vec[s]) idx = IDX_W'(s);
        end
        any = |hit_vec;
    end
endmodule

// File: rtl/vpa_tlb.sv
`timescale 1ns/1ps
// Top: fully associative translation buffer with a per-slot page size.
// It has a write port, a direct read of one slot's translation word, and an
// associative lookup that returns the winning slot's translation word.
// Reads are combinational from registered state. Assumes a synchronous
// active-low reset.
module vpa_tlb
    import vtlb_pkg::*;
#(
    parameter int SLOTS   = 64,
    parameter int ADDR_W  = 64,
    parameter int IDX_LSB = 3,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_tag,
    input  logic [WORD_W-1:0] wr_entry,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_entry,
    input  logic [WORD_W-1:0] lk_tag,
    output logic [WORD_W-1:0] lk_entry,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [IDX_W-1:0]  lk_idx
);
    logic [SLOTS-1:0][WORD_W-1:0] tag_q;
    logic [SLOTS-1:0][WORD_W-1:0] ent_q;
    logic [SLOTS-1:0]             hit_vec;
    logic                         any_hit;
    logic [IDX_W-1:0]             win_idx;
    logic [IDX_W-1:0]             rd_idx;
    logic                         unused_addr;

    vtlb_store #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_entry(wr_entry), .tag_q(tag_q), .ent_q(ent_q)
    );

    vtlb_match #(.SLOTS(SLOTS)) u_match (
        .tag_q(tag_q), .ent_q(ent_q), .lk_tag(lk_tag), .hit_vec(hit_vec)
    );

    vtlb_prio #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_prio (
        .hit_vec(hit_vec), .any(any_hit), .idx(win_idx)
    );

    // Direct read: slot number taken from the address field.
    always_comb begin
        rd_idx   = rd_addr[IDX_LSB +: IDX_W];
        rd_entry = ent_q[rd_idx];
    end

    assign unused_addr = ^rd_addr;

    // Lookup outputs: the winning translation word, or zeros on a miss.
    always_comb begin
        lk_hit   = any_hit;
        lk_miss  = !any_hit;
        lk_idx   = win_idx;
        lk_entry = any_hit ? ent_q[win_idx] : '0;
    end
endmodule

// File: rtl/vtlb_chk.sv
`timescale 1ns/1ps
// Checker for vpa_tlb, attached by bind. Assumes inputs are known at each
// rising edge and that the reset is synchronous.
module vtlb_chk #(
    parameter int SLOTS   = 64,
    parameter int IDX_LSB = 3,
    parameter int IDX_W   = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [63:0]       wr_entry,
    input logic [63:0]       rd_addr,
    input logic [63:0]       rd_entry,
    input logic [63:0]       lk_entry,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic [IDX_W-1:0]  lk_idx
);
    // R8: a miss gives a clean zero result.
    a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_entry == '0 && lk_idx == '0 && !lk_hit));

    // R3: a returned translation word always carries a set valid bit.
    a_r3_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_entry[63] && !lk_miss));

    // R2: one edge after reset is sampled, nothing hits.
    a_r2_reset_no_hit: assert property (@(posedge clk)
        !rst_n |=> !lk_hit);

    // R1: a write shows on a direct read of its slot at the next edge.
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_addr[IDX_LSB +: IDX_W] != $past(wr_idx)) ||
                   (rd_entry == $past(wr_entry))));
endmodule

bind vpa_tlb vtlb_chk #(.SLOTS(SLOTS), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_entry(wr_entry), .rd_addr(rd_addr), .rd_entry(rd_entry),
    .lk_entry(lk_entry), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_idx(lk_idx)
);

// File: tb/sim_vpa_tlb.sv
`timescale 1ns/1ps
module sim_vpa_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_tag = '0, wr_entry = '0, rd_addr = '0, lk_tag = '0;
    logic [63:0] rd_entry, lk_entry;
    logic        lk_hit, lk_miss;
    logic [5:0]  lk_idx;

    int checks = 0;
    int errors = 0;
    logic [63:0] mtag [64];
    logic [63:0] ment [64];

    always #2.5 clk = ~clk;

    vpa_tlb u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_entry(wr_entry), .rd_addr(rd_addr),
        .rd_entry(rd_entry), .lk_tag(lk_tag), .lk_entry(lk_entry),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_idx(lk_idx)
    );

    // R4 masks, written out from the requirement.
    function automatic logic [63:0] exp_mask(input logic [1:0] c);
        case (c)
            2'd0:    return 64'hFFFF_FFFF_FFFF_FFFF;
            2'd1:    return 64'hFFFF_FFFF_FFFF_0FFF;
            2'd2:    return 64'hFFFF_FFFF_FFF8_0FFF;
            default: return 64'hFFFF_FFFF_FFC0_0FFF;
        endcase
    endfunction

    function automatic logic [63:0] mk_ent(input logic v, input logic [1:0] sz, input logic [63:0] body);
        return {v, sz, body[60:0]};
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // Compare all outputs against the model. Inputs are applied on a falling edge.
    task automatic probe(input logic [63:0] t, input logic [63:0] a, input string req);
        logic ehit; logic [5:0] eidx; logic [63:0] eent, erd;
        ehit = 1'b0; eidx = '0; eent = '0;
        for (int i = 0; i < 64; i++) begin
            if (!ehit && ment[i][63] && (((mtag[i] ^ t) & exp_mask(ment[i][62:61])) == '0)) begin
                ehit = 1'b1; eidx = 6'(i); eent = ment[i];
            end
        end
        erd = ment[a[8:3]];
        lk_tag = t; rd_addr = a;
        #1;
        checks++;
        if (lk_hit !== ehit || lk_miss !== !ehit || lk_idx !== eidx ||
            lk_entry !== eent || rd_entry !== erd) begin
            errors++;
            $display("FAIL %s hit=%b idx=%0d ent=%h rd=%h expected hit=%b idx=%0d ent=%h rd=%h",
                     req, lk_hit, lk_idx, lk_entry, rd_entry, ehit, eidx, eent, erd);
        end
    endtask

    task automatic look(input logic [63:0] t, input logic [5:0] s, input string req);
        @(negedge clk);
        probe(t, {55'd0, s, 3'd0}, req);
    endtask

    task automatic write_slot(input logic [5:0] s, input logic [63:0] t, input logic [63:0] e);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = s; wr_tag = t; wr_entry = e;
        @(posedge clk);
        mtag[s] = t; ment[s] = e;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 64; i++) ment[i][63] = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] base;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: after reset no slot is valid.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rd_addr = {55'd0, 6'(k * 17), 3'd0};
            #1; checks++;
            if (rd_entry[63] !== 1'b0 || lk_hit !== 1'b0) begin
                errors++;
                $display("FAIL R2 valid=%b hit=%b expected 0 0", rd_entry[63], lk_hit);
            end
        end
        // Fill every slot with an invalid entry (R3: none may hit).
        for (int i = 0; i < 64; i++) write_slot(6'(i), rnd64(), mk_ent(1'b0, 2'(i), rnd64()));
        look(mtag[9], 6'd9, "R3");   // R3 invalid slot, same tag: miss
        look(mtag[9], 6'd9, "R7");   // R7 direct read of an invalid slot
        look(64'h0, 6'd0, "R8");     // R8 plain miss

        // R4 size code 3 at slot 5: bits 21:12 ignored, bit 22 compared.
        base = 64'h1234_5678_9ABC_DEF0;
        write_slot(6'd5, base, mk_ent(1'b1, 2'd3, 64'hAAAA));
        look(base ^ 64'h0000_0000_003F_F000, 6'd5, "R4");
        look(base ^ 64'h0000_0000_0040_0000, 6'd5, "R4");
        look(base ^ 64'h0000_0000_0000_0800, 6'd5, "R4");
        look(base, 6'd5, "R5");
        // R4 size code 1 at slot 40: bits 15:12 ignored, bit 16 compared.
        write_slot(6'd40, 64'h00FF_0000_0000_3000, mk_ent(1'b1, 2'd1, 64'h40));
        look(64'h00FF_0000_0000_F000, 6'd40, "R4");
        look(64'h00FF_0000_0001_3000, 6'd40, "R4");
        // R4 size code 2 at slot 41: bit 18 ignored, bit 19 compared.
        write_slot(6'd41, 64'h0A00_0000_0000_0000, mk_ent(1'b1, 2'd2, 64'h41));
        look(64'h0A00_0000_0004_0000, 6'd41, "R4");
        look(64'h0A00_0000_0008_0000, 6'd41, "R4");
        // R6: slots 10 and 3 share a tag; slot 3 wins.
        write_slot(6'd10, 64'hBEEF, mk_ent(1'b1, 2'd0, 64'h10));
        write_slot(6'd3,  64'hBEEF, mk_ent(1'b1, 2'd0, 64'h3));
        look(64'hBEEF, 6'd10, "R6");
        // R1: a lookup in the write cycle sees old contents; after the edge, the new.
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd20; wr_tag = 64'hC0DE; wr_entry = mk_ent(1'b1, 2'd0, 64'h20);
        probe(64'hC0DE, {55'd0, 6'd20, 3'd0}, "R1");
        @(posedge clk);
        mtag[20] = 64'hC0DE; ment[20] = mk_ent(1'b1, 2'd0, 64'h20);
        #1; probe(64'hC0DE, {55'd0, 6'd20, 3'd0}, "R9");
        @(negedge clk); wr_en = 1'b0;
        look(64'hC0DE, 6'd20, "R1");

        // Random mix of writes and lookups.
        for (int n = 0; n < 3000; n++) begin
            int j;
            j = int'($urandom_range(0, 63));
            if ($urandom_range(0, 3) == 0)
                write_slot(6'(j), rnd64(), mk_ent($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), rnd64()));
            else if ($urandom_range(0, 1) == 0)
                look(mtag[j] ^ ({32'd0, $urandom} & 64'h0000_0000_007F_F000), 6'($urandom_range(0, 63)), "R5");
            else
                look(rnd64(), 6'($urandom_range(0, 63)), "R8");
            if (n == 1500) begin
                pulse_reset();
                look(mtag[3], 6'd3, "R2");
            end
        end
        finish_run();
    end
endmodule